// File: doc/BRIEF.md
# Sampled-Core Cache Policy Selector

This block picks the last-level cache policy for a group of GPU cores by running a live experiment on two of them. One sampled core always bypasses the shared cache. A second sampled core always inserts its lines at the MRU position. Over a programmable window of cycles, the block counts the instructions each sampled core retires. When the window closes, it compares the throughput gain of the caching core with a programmable threshold.

The result is a cache-friendliness flag and a partition mask bit. The mask is the inverse of the flag, and a way-partitioning unit uses it to grant the GPU only a minimal share. Every other GPU core is a follower and is given the policy that the last decision favours. Retire pulses from followers play no part in the measurement.

Top module: `cs_policy_ctrl`

## Requirements
- R1: The policy select of core `BYP_CORE` (default 0) is always 0, where 0 means bypass the last-level cache.
- R2: The policy select of core `MRU_CORE` (default 1) is always 1, where 1 means insert at MRU in the last-level cache.
- R3: Every other core's policy select equals the current cache-friendliness flag, so a friendly workload gives 1 (MRU insertion) and an unfriendly one gives 0 (bypass).
- R4: A window lasts `period_i` clock cycles, counted from the first cycle after reset or after the previous window; a value of 0 is treated as 1. The flag and mask change only on the clock edge that ends a window.
- R5: At the end of a window, the flag is set when the MRU core's retire count minus the bypass core's count, floored at zero, is strictly greater than `thresh_i`. In every other case the flag is cleared.
- R6: `part_mask_o` is 1 exactly when the flag is 0.
- R7: Retire pulses seen in every cycle of a window, including its last cycle, are counted. Both counts start from zero in each new window.
- R8: Out of reset the flag is 1 and the mask is 0. These values hold until the first window ends.
- R9: Retire pulses from follower cores have no effect on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_i | input | NUM_CORES | One retire pulse per core per cycle |
| thresh_i | input | PERIOD_W | Minimum throughput gain, exclusive |
| period_i | input | PERIOD_W | Window length in cycles |
| pol_sel_o | output | NUM_CORES | Per-core policy: 0 bypass, 1 MRU insertion |
| cache_friendly_o | output | 1 | Latched cache-friendliness decision |
| part_mask_o | output | 1 | Partition mask, inverse of the decision |

## Verification
The bench builds the block with four cores and an 8-bit window width. Windows of eight cycles then finish in a handful of clock edges. Four cores leave two followers, so the follower fan-out and the claim that follower pulses are ignored can both be observed. Short windows also make each corner within reach of a directed task: a gain equal to the threshold, a bypass core that outruns the MRU core, counts that must clear between back-to-back windows, and a decision that must hold until the final cycle of a window.

// File: rtl/cs_pkg.sv
package cs_pkg;
  // Policy select encoding driven to each core
  typedef enum logic {
    POL_BYPASS = 1'b0,
    POL_MRU    = 1'b1
  } cs_pol_e;
endpackage

// File: rtl/cs_window_timer.sv
module cs_window_timer #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                tick_o
);
  localparam int EXT_W = PERIOD_W + 1;

  logic [PERIOD_W-1:0] cyc_q, cyc_d;
  logic [EXT_W-1:0]    cyc_inc;

  always_comb begin
    cyc_inc = {1'b0, cyc_q} + EXT_W'(1);
    tick_o  = (cyc_inc >= {1'b0, period_i});
    cyc_d   = tick_o ? '0 : cyc_inc[PERIOD_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_q <= '0;
    else        cyc_q <= cyc_d;
  end

  AST_WINDOW_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cyc_q == '0)); // R4
endmodule

// File: rtl/cs_retire_counter.sv
module cs_retire_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] total_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    total_o = cnt_q + CNT_W'(pulse_i);
    cnt_en  = pulse_i | clr_i;
    cnt_d   = clr_i ? '0 : total_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_COUNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/cs_decide.sv
module cs_decide #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] mru_total_i,
  input  logic [CNT_W-1:0] byp_total_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic             friendly_o
);
  logic [CNT_W-1:0] gain;
  logic             verdict;
  logic             friendly_q;

  always_comb begin
    gain    = (mru_total_i > byp_total_i) ? (mru_total_i - byp_total_i) : '0;
    verdict = (gain > thresh_i);
  end

  // Reset value favours caching until the first window closes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      friendly_q <= 1'b1;
    else if (tick_i) friendly_q <= verdict;
  end

  assign friendly_o = friendly_q;

  AST_HOLD_MID_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(friendly_q)); // R4
  AST_GAIN_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (friendly_q == ($past(mru_total_i) > $past(byp_total_i) + $past(thresh_i)))); // R5
endmodule

// File: rtl/cs_policy_ctrl.sv
module cs_policy_ctrl
  import cs_pkg::*;
#(
  parameter int NUM_CORES = 6,
  parameter int PERIOD_W  = 16,
  parameter int BYP_CORE  = 0,
  parameter int MRU_CORE  = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CORES-1:0] retire_i,
  input  logic [PERIOD_W-1:0]  thresh_i,
  input  logic [PERIOD_W-1:0]  period_i,
  output logic [NUM_CORES-1:0] pol_sel_o,
  output logic                 cache_friendly_o,
  output logic                 part_mask_o
);
  // A window never exceeds 2^PERIOD_W-1 cycles, so counts fit this width
  localparam int CNT_W = PERIOD_W;

  logic             tick;
  logic [CNT_W-1:0] mru_total, byp_total;
  logic             friendly;
  logic             unused_follower_pulses;

  assign unused_follower_pulses = ^retire_i;

  cs_window_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .tick_o(tick)
  );

  cs_retire_counter #(.CNT_W(CNT_W)) u_cnt_mru (
    .clk(clk), .rst_n(rst_n), .pulse_i(retire_i[MRU_CORE]),
    .clr_i(tick), .total_o(mru_total)
  );

  cs_retire_counter #(.CNT_W(CNT_W)) u_cnt_byp (
    .clk(clk), .rst_n(rst_n), .pulse_i(retire_i[BYP_CORE]),
    .clr_i(tick), .total_o(byp_total)
  );

  cs_decide #(.CNT_W(CNT_W)) u_decide (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .mru_total_i(mru_total), .byp_total_i(byp_total),
    .thresh_i(thresh_i), .friendly_o(friendly)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_pol
    if (c == BYP_CORE) begin : g_byp
      assign pol_sel_o[c] = POL_BYPASS;
    end else if (c == MRU_CORE) begin : g_mru
      assign pol_sel_o[c] = POL_MRU;
    end else begin : g_fol
      assign pol_sel_o[c] = friendly ? POL_MRU : POL_BYPASS;
    end
  end

  assign cache_friendly_o = friendly;
  assign part_mask_o      = ~friendly;

  AST_BYPASS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    pol_sel_o[BYP_CORE] == POL_BYPASS); // R1
  AST_MRU_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    pol_sel_o[MRU_CORE] == POL_MRU); // R2
  AST_MASK_OPPOSES: assert property (@(posedge clk) disable iff (!rst_n)
    part_mask_o != cache_friendly_o); // R6
  AST_MASK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(part_mask_o)); // R4

  for (genvar f = 0; f < NUM_CORES; f++) begin : g_fol_chk
    if (f != BYP_CORE && f != MRU_CORE) begin : g_on
      AST_FOLLOWER_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        pol_sel_o[f] == cache_friendly_o); // R3
    end
  end
endmodule

// File: tb/cs_policy_ctrl_test.sv
`timescale 1ns/1ps
module cs_policy_ctrl_test;
  localparam int NC = 4;
  localparam int PW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NC-1:0] retire;
  logic [PW-1:0] thresh, period;
  logic [NC-1:0] pol_sel;
  logic          friendly, mask;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  cs_policy_ctrl #(.NUM_CORES(NC), .PERIOD_W(PW), .BYP_CORE(0), .MRU_CORE(1)) uut (
    .clk(clk), .rst_n(rst_n), .retire_i(retire), .thresh_i(thresh),
    .period_i(period), .pol_sel_o(pol_sel), .cache_friendly_o(friendly),
    .part_mask_o(mask)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit expect_friendly(int n_mru, int n_byp, int thr);
    int g = (n_mru > n_byp) ? n_mru - n_byp : 0;
    return g > thr;
  endfunction

  // Checks every output against one expected decision value
  task automatic check_outputs(string req, bit exp_f);
    check({req, " flag"}, 32'(friendly), 32'(exp_f));
    check("R6 mask", 32'(mask), 32'(!exp_f));
    check("R1 bypass core", 32'(pol_sel[0]), 32'd0);
    check("R2 mru core", 32'(pol_sel[1]), 32'd1);
    check("R3 followers", 32'(pol_sel[3:2]), exp_f ? 32'd3 : 32'd0);
  endtask

  task automatic do_reset(int p, int thr);
    rst_n  = 1'b0;
    retire = '0;
    period = PW'(p);
    thresh = PW'(thr);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Called at a falling edge; drives one cycle and returns at the next falling edge
  task automatic step(bit m, bit b, bit f);
    retire = {f, f, m, b};
    @(posedge clk);
    @(negedge clk);
    retire = '0;
  endtask

  task automatic run_window(int p, int n_mru, int n_byp, int n_fol);
    for (int k = 0; k < p; k++) step(k < n_mru, k < n_byp, k < n_fol);
  endtask

  task automatic t_reset_state();
    do_reset(8, 3);
    check_outputs("R8 reset", 1'b1);
  endtask

  task automatic t_friendly();
    do_reset(8, 3);
    run_window(8, 8, 2, 0);
    check_outputs("R5 gain 6 over 3", expect_friendly(8, 2, 3));
  endtask

  task automatic t_unfriendly();
    do_reset(8, 3);
    run_window(8, 4, 3, 0);
    check_outputs("R5 gain 1 over 3", expect_friendly(4, 3, 3));
  endtask

  task automatic t_equal_threshold();
    do_reset(8, 3);
    run_window(8, 6, 3, 0);
    check_outputs("R5 gain equals threshold", expect_friendly(6, 3, 3));
  endtask

  task automatic t_bypass_faster();
    do_reset(8, 0);
    run_window(8, 2, 8, 0);
    check_outputs("R5 floor at zero", expect_friendly(2, 8, 0));
  endtask

  task automatic t_counts_clear();
    do_reset(8, 5);
    run_window(8, 8, 0, 0);
    check_outputs("R7 first window", expect_friendly(8, 0, 5));
    run_window(8, 2, 0, 0);
    check_outputs("R7 second window cleared", expect_friendly(2, 0, 5));
  endtask

  task automatic t_last_cycle_counts();
    // MRU pulse only in the final cycle: gain 1 over threshold 0
    do_reset(4, 0);
    step(0, 0, 0); step(0, 0, 0); step(0, 0, 0);
    step(1, 0, 0);
    check_outputs("R7 last cycle pulse", 1'b1);
    run_window(4, 0, 0, 0);
    check_outputs("R7 empty window", 1'b0);
  endtask

  task automatic t_followers_ignored();
    do_reset(8, 0);
    run_window(8, 0, 0, 8);
    check_outputs("R9 follower pulses", expect_friendly(0, 0, 0));
  endtask

  task automatic t_hold_mid_window();
    do_reset(8, 0);
    run_window(8, 8, 0, 0);
    check_outputs("R4 first decision", 1'b1);
    run_window(7, 0, 7, 0);
    check_outputs("R4 held before boundary", 1'b1);
    step(0, 1, 0);
    check_outputs("R4 updated at boundary", 1'b0);
  endtask

  task automatic t_zero_period();
    // Zero acts as a single-cycle window
    do_reset(0, 0);
    step(1, 0, 0);
    check_outputs("R4 zero period first", 1'b1);
    step(0, 0, 0);
    check_outputs("R4 zero period second", 1'b0);
  endtask

  initial begin
    t_reset_state();
    t_friendly();
    t_unfriendly();
    t_equal_threshold();
    t_bypass_faster();
    t_counts_clear();
    t_last_cycle_counts();
    t_followers_ignored();
    t_hold_mid_window();
    t_zero_period();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule